// File: doc/BRIEF.md
# Lockable Per-Thread Mitigation Option Register Unit

This unit sits inside a processor core and keeps one 64-bit mitigation option register for every hardware thread. A single request port, carrying a thread index, reads and writes these registers. The unit enforces the field rules itself. Some fields exist only while a matching capability input is high. One lock input per thread pins that thread's transaction-allow field at zero. A core-wide one-way lock, set by a load-time event, pins every thread's gather-disable field at zero until reset.

From the stored fields the unit drives three status results. Per thread, it drives whether transactions may start and whether the random-number mitigation applies. For the core, it drives whether the gather mitigation is off, which is true only when every thread has opted out. A write that touches reserved bits, or that names a thread that does not exist, is refused. In place of a fault, the unit raises a one-cycle error pulse.

Field positions, which software decodes: bit 0 random-number opt-out, bit 1 transaction allow, bit 2 transaction-lock status, bit 3 fill-buffer-clear disable, bit 4 gather disable, bit 5 gather lock, bit 6 ignore user monitor, bit 7 monitor flush. Bits 63:8 are reserved.

Top module: `mitig_opt_regs`

## Requirements
- R1: After reset, every thread reads 0x40 when the user-monitor capability is high (bit 6 resets to 1, all other bits to 0). The gather-off output is 0, every txn_ok is 0 and every rng_mitig_on is 1.
- R2: A write updates the selected thread at the clock edge that samples the request and leaves all other threads unchanged. A read returns rsp_valid with the data one cycle after the request.
- R3: txn_ok[t] is 1 only when bit 1 of thread t is 1 and txn_dis[t] is 0. While txn_lock_in[t] is 1, bit 2 reads 1, bit 1 reads 0, writes to bit 1 are ignored and the stored bit 1 is cleared. Bit 1 stays 0 after the lock drops until it is written again.
- R4: rng_mitig_on[t] is 1 when bit 0 of thread t is 0 or when enclave[t] is 1.
- R5: Bits 3, 6 and 7 are each gated by their own capability input (cap_fbclr, cap_umon, cap_monflush). While the capability is 0, the bit reads 0 and writes to it are dropped without changing the stored value.
- R6: gath_mitig_off is 1 exactly when bit 4 reads 1 in every thread. It is registered, so it changes one cycle after the register change.
- R7: A one-cycle load_evt sets bit 5 in every thread until the next reset. While bit 5 is set, bit 4 reads 0 and writes to bit 4 are ignored. gath_mitig_off is 0 from the second cycle after the event.
- R8: A write with any of bits 63:8 set changes no thread and produces a wr_err pulse of exactly one cycle, one cycle after the request. Ones written to bits 2 and 5 are silently ignored.
- R9: A request whose thread index is NUM_THREADS or higher writes nothing and pulses wr_err. Reading such an index returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_thread | input | TID_W | Target thread index |
| req_wdata | input | 64 | Write data |
| cap_fbclr | input | 1 | Capability for bit 3 |
| cap_umon | input | 1 | Capability for bit 6 |
| cap_monflush | input | 1 | Capability for bit 7 |
| load_evt | input | 1 | Load-time event that sets the gather lock |
| txn_lock_in | input | NUM_THREADS | Per-thread transaction lock status |
| txn_dis | input | NUM_THREADS | Per-thread transactional-disable control |
| enclave | input | NUM_THREADS | Thread is running in secure-enclave mode |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| wr_err | output | 1 | One-cycle pulse for a refused write |
| txn_ok | output | NUM_THREADS | Transactions may start on thread |
| rng_mitig_on | output | NUM_THREADS | Random-number mitigation applies on thread |
| gath_mitig_off | output | 1 | Core-level gather mitigation disabled |

## Verification
The bench builds the unit with NUM_THREADS set to 3. This gives a two-bit index in which the value 3 decodes to no thread, so the out-of-range refusal path can be reached. It also makes the core-wide AND span an odd number of threads, so the gather-off output must wait for the third thread's opt-out. The capability inputs are toggled at run time, which shows that dropped writes leave stored values intact.

// File: rtl/mitig_opt_pkg.sv
package mitig_opt_pkg;

    localparam int REG_W   = 64;
    localparam int FIELD_W = 8;

    // Field positions (decoded by software)
    localparam int B_RNG  = 0;
    localparam int B_TXA  = 1;
    localparam int B_TLK  = 2;
    localparam int B_FBC  = 3;
    localparam int B_GDIS = 4;
    localparam int B_GLK  = 5;
    localparam int B_UMON = 6;
    localparam int B_MONF = 7;

    localparam logic [REG_W-1:0] RSVD_MASK =
        ~{{(REG_W-FIELD_W){1'b0}}, {FIELD_W{1'b1}}};

    typedef struct packed {
        logic mon_flush;
        logic umon_ign;
        logic gath_dis;
        logic fbclr_dis;
        logic txn_allow;
        logic rng_optout;
    } opt_state_t;

    typedef struct packed {
        logic fbclr;
        logic umon;
        logic monflush;
    } cap_t;

    localparam opt_state_t OPT_RESET = '{
        mon_flush:  1'b0,
        umon_ign:   1'b1,
        gath_dis:   1'b0,
        fbclr_dis:  1'b0,
        txn_allow:  1'b0,
        rng_optout: 1'b0
    };

    // Software-visible image of one thread's register
    function automatic logic [REG_W-1:0] compose_view(
        input opt_state_t s,
        input cap_t       c,
        input logic       tlock,
        input logic       glock
    );
        logic [REG_W-1:0] v;
        v         = '0;
        v[B_RNG]  = s.rng_optout;
        v[B_TXA]  = s.txn_allow & ~tlock;
        v[B_TLK]  = tlock;
        v[B_FBC]  = s.fbclr_dis & c.fbclr;
        v[B_GDIS] = s.gath_dis & ~glock;
        v[B_GLK]  = glock;
        v[B_UMON] = s.umon_ign & c.umon;
        v[B_MONF] = s.mon_flush & c.monflush;
        return v;
    endfunction

    // Merge accepted write data into the stored fields
    function automatic opt_state_t merge_write(
        input opt_state_t       s,
        input logic [REG_W-1:0] wd,
        input cap_t             c,
        input logic             tlock,
        input logic             glock
    );
        opt_state_t n;
        n = s;
        n.rng_optout = wd[B_RNG];
        if (!tlock)     n.txn_allow = wd[B_TXA];
        if (c.fbclr)    n.fbclr_dis = wd[B_FBC];
        if (!glock)     n.gath_dis  = wd[B_GDIS];
        if (c.umon)     n.umon_ign  = wd[B_UMON];
        if (c.monflush) n.mon_flush = wd[B_MONF];
        return n;
    endfunction

endpackage

// File: rtl/mitig_req_decode.sv
module mitig_req_decode
    import mitig_opt_pkg::*;
#(
    parameter int NUM_THREADS = 2,
    parameter int TID_W       = 1
) (
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [TID_W-1:0]       req_thread,
    input  logic [REG_W-1:0]       req_wdata,
    output logic [NUM_THREADS-1:0] wr_sel,
    output logic                   wr_reject,
    output logic                   rd_fire,
    output logic                   idx_ok
);

    logic rsvd_hit;
    logic wr_req;

    assign idx_ok    = ({1'b0, req_thread} < (TID_W+1)'(NUM_THREADS));
    assign rsvd_hit  = |(req_wdata & RSVD_MASK);
    assign wr_req    = req_valid & req_write;
    assign wr_reject = wr_req & (~idx_ok | rsvd_hit);
    assign rd_fire   = req_valid & ~req_write;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_sel
        assign wr_sel[t] = wr_req & ~wr_reject & (req_thread == TID_W'(t));
    end

endmodule

// File: rtl/mitig_thread_reg.sv
module mitig_thread_reg
    import mitig_opt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  cap_t             caps,
    input  logic             txn_lock,
    input  logic             gath_lock,
    input  logic             txn_dis,
    input  logic             enclave,
    output logic [REG_W-1:0] view,
    output logic             txn_ok,
    output logic             rng_on
);

    opt_state_t state_q;
    opt_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (wr_en)     state_d = merge_write(state_q, wr_data, caps, txn_lock, gath_lock);
        if (txn_lock)  state_d.txn_allow = 1'b0;
        if (gath_lock) state_d.gath_dis  = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= OPT_RESET;
        else     state_q <= state_d;
    end

    assign view   = compose_view(state_q, caps, txn_lock, gath_lock);
    assign txn_ok = view[B_TXA] & ~txn_dis;
    assign rng_on = ~view[B_RNG] | enclave;

endmodule

// File: rtl/mitig_gather_agg.sv
module mitig_gather_agg #(
    parameter int NUM_THREADS = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_THREADS-1:0] dis_vec,
    output logic                   core_off
);

    always_ff @(posedge clk) begin
        if (rst) core_off <= 1'b0;
        else     core_off <= &dis_vec;
    end

endmodule

// File: rtl/mitig_opt_regs.sv
module mitig_opt_regs
    import mitig_opt_pkg::*;
#(
    parameter int  NUM_THREADS = 2,
    localparam int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [TID_W-1:0]       req_thread,
    input  logic [63:0]            req_wdata,
    input  logic                   cap_fbclr,
    input  logic                   cap_umon,
    input  logic                   cap_monflush,
    input  logic                   load_evt,
    input  logic [NUM_THREADS-1:0] txn_lock_in,
    input  logic [NUM_THREADS-1:0] txn_dis,
    input  logic [NUM_THREADS-1:0] enclave,
    output logic                   rsp_valid,
    output logic [63:0]            rsp_rdata,
    output logic                   wr_err,
    output logic [NUM_THREADS-1:0] txn_ok,
    output logic [NUM_THREADS-1:0] rng_mitig_on,
    output logic                   gath_mitig_off
);

    cap_t                   caps;
    logic                   glock_q;
    logic [NUM_THREADS-1:0] wr_sel;
    logic                   wr_reject;
    logic                   rd_fire;
    logic                   idx_ok;
    logic [REG_W-1:0]       view [NUM_THREADS];
    logic [NUM_THREADS-1:0] gdis_eff;
    logic [REG_W-1:0]       rd_mux;

    assign caps = '{fbclr: cap_fbclr, umon: cap_umon, monflush: cap_monflush};

    mitig_req_decode #(
        .NUM_THREADS (NUM_THREADS),
        .TID_W       (TID_W)
    ) u_dec (
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_thread (req_thread),
        .req_wdata  (req_wdata),
        .wr_sel     (wr_sel),
        .wr_reject  (wr_reject),
        .rd_fire    (rd_fire),
        .idx_ok     (idx_ok)
    );

    // One-way core lock, cleared only by reset
    always_ff @(posedge clk) begin
        if (rst)           glock_q <= 1'b0;
        else if (load_evt) glock_q <= 1'b1;
    end

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        mitig_thread_reg u_reg (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (wr_sel[t]),
            .wr_data   (req_wdata),
            .caps      (caps),
            .txn_lock  (txn_lock_in[t]),
            .gath_lock (glock_q),
            .txn_dis   (txn_dis[t]),
            .enclave   (enclave[t]),
            .view      (view[t]),
            .txn_ok    (txn_ok[t]),
            .rng_on    (rng_mitig_on[t])
        );
        assign gdis_eff[t] = view[t][B_GDIS];
    end

    mitig_gather_agg #(
        .NUM_THREADS (NUM_THREADS)
    ) u_agg (
        .clk      (clk),
        .rst      (rst),
        .dis_vec  (gdis_eff),
        .core_off (gath_mitig_off)
    );

    always_comb begin
        rd_mux = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (req_thread == TID_W'(t)) rd_mux = view[t];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            wr_err    <= 1'b0;
        end else begin
            rsp_valid <= rd_fire;
            rsp_rdata <= (rd_fire && idx_ok) ? rd_mux : '0;
            wr_err    <= wr_reject;
        end
    end

endmodule

// File: rtl/mitig_opt_regs_chk.sv
module mitig_opt_regs_chk #(
    parameter int NUM_THREADS = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   req_valid,
    input logic                   req_write,
    input logic                   load_evt,
    input logic [NUM_THREADS-1:0] txn_lock_in,
    input logic [NUM_THREADS-1:0] enclave,
    input logic                   rsp_valid,
    input logic                   wr_err,
    input logic [NUM_THREADS-1:0] txn_ok,
    input logic [NUM_THREADS-1:0] rng_mitig_on,
    input logic                   gath_mitig_off
);

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !req_write)) else $error("read response without request"); // R2

    AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> $past(req_valid && req_write)) else $error("error pulse without write"); // R8

    AST_GLOCK_FORCES_ON: assert property (@(posedge clk) disable iff (rst)
        $past(load_evt, 2) |-> !gath_mitig_off) else $error("gather off despite lock"); // R7

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        AST_TXN_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
            txn_lock_in[t] |-> !txn_ok[t]) else $error("transactions allowed while locked"); // R3

        AST_ENCLAVE_MITIG: assert property (@(posedge clk) disable iff (rst)
            enclave[t] |-> rng_mitig_on[t]) else $error("enclave without rng mitigation"); // R4
    end

endmodule

bind mitig_opt_regs mitig_opt_regs_chk #(.NUM_THREADS(NUM_THREADS)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .load_evt       (load_evt),
    .txn_lock_in    (txn_lock_in),
    .enclave        (enclave),
    .rsp_valid      (rsp_valid),
    .wr_err         (wr_err),
    .txn_ok         (txn_ok),
    .rng_mitig_on   (rng_mitig_on),
    .gath_mitig_off (gath_mitig_off)
);

// File: tb/mitig_opt_regs_test.sv
`timescale 1ns/1ps
module mitig_opt_regs_test;

    localparam int NT = 3;
    localparam int TW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [TW-1:0] req_thread = '0;
    logic [63:0]   req_wdata = '0;
    logic          cap_fbclr = 1'b1;
    logic          cap_umon = 1'b1;
    logic          cap_monflush = 1'b1;
    logic          load_evt = 1'b0;
    logic [NT-1:0] txn_lock_in = '0;
    logic [NT-1:0] txn_dis = '0;
    logic [NT-1:0] enclave = '0;
    logic          rsp_valid;
    logic [63:0]   rsp_rdata;
    logic          wr_err;
    logic [NT-1:0] txn_ok;
    logic [NT-1:0] rng_mitig_on;
    logic          gath_mitig_off;

    int errors = 0;
    int checks = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    mitig_opt_regs #(.NUM_THREADS(NT)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_thread(req_thread), .req_wdata(req_wdata), .cap_fbclr(cap_fbclr),
        .cap_umon(cap_umon), .cap_monflush(cap_monflush), .load_evt(load_evt),
        .txn_lock_in(txn_lock_in), .txn_dis(txn_dis), .enclave(enclave),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .wr_err(wr_err),
        .txn_ok(txn_ok), .rng_mitig_on(rng_mitig_on), .gath_mitig_off(gath_mitig_off)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int t, logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_thread = TW'(t); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
    endtask

    task automatic rd(int t, logic [63:0] e, string req);
        exp_q.push_back(e);
        tag_q.push_back(req);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_thread = TW'(t);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Monitor: compares read responses against the scoreboard
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R2: actual=unexpected response %h expected=none", rsp_rdata);
            end else begin
                chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 gath_mitig_off", 64'(gath_mitig_off), 64'd0);
        chk("R1 txn_ok", 64'(txn_ok), 64'd0);
        chk("R1 rng_mitig_on", 64'(rng_mitig_on), 64'h7);
        for (int t = 0; t < NT; t++) rd(t, 64'h40, "R1 reset value");

        // R2 write timing and isolation
        wr(1, 64'h03);
        chk("R3 txn_ok after allow", 64'(txn_ok), 64'h2);
        rd(1, 64'h03, "R2 written thread");
        rd(0, 64'h40, "R2 other thread unchanged");

        // R4 random-number mitigation
        chk("R4 opt-out thread", 64'(rng_mitig_on), 64'h5);
        @(negedge clk); enclave[1] = 1'b1; #1;
        chk("R4 enclave forces on", 64'(rng_mitig_on[1]), 64'd1);
        enclave[1] = 1'b0;

        // R3 transaction control and lock
        txn_dis[1] = 1'b1; #1;
        chk("R3 txn_dis blocks", 64'(txn_ok[1]), 64'd0);
        txn_dis[1] = 1'b0;
        @(negedge clk); txn_lock_in[1] = 1'b1; #1;
        chk("R3 lock blocks", 64'(txn_ok[1]), 64'd0);
        rd(1, 64'h05, "R3 locked image");
        wr(1, 64'h03);
        rd(1, 64'h05, "R3 write ignored under lock");
        @(negedge clk); txn_lock_in[1] = 1'b0;
        rd(1, 64'h01, "R3 allow stays cleared");
        chk("R3 txn_ok after unlock", 64'(txn_ok[1]), 64'd0);

        // R5 capability-gated fields
        cap_fbclr = 1'b0;
        wr(0, 64'h08);
        rd(0, 64'h00, "R5 fbclr dropped");
        cap_fbclr = 1'b1;
        rd(0, 64'h00, "R5 fbclr not stored");
        wr(0, 64'h08);
        rd(0, 64'h08, "R5 fbclr written");
        cap_umon = 1'b0;
        rd(2, 64'h00, "R5 umon hidden");
        cap_monflush = 1'b0;
        wr(2, 64'h80);
        rd(2, 64'h00, "R5 monflush dropped");
        cap_monflush = 1'b1; cap_umon = 1'b1;
        rd(2, 64'h40, "R5 stored values kept");

        // R6 core-wide aggregation
        wr(0, 64'h10);
        wr(1, 64'h10);
        @(negedge clk);
        chk("R6 two of three", 64'(gath_mitig_off), 64'd0);
        wr(2, 64'h10);
        chk("R6 registered delay", 64'(gath_mitig_off), 64'd0);
        @(negedge clk);
        chk("R6 all threads", 64'(gath_mitig_off), 64'd1);

        // R8 reserved bits
        wr(1, 64'h8000_0000_0000_0001);
        chk("R8 error pulse", 64'(wr_err), 64'd1);
        @(negedge clk);
        chk("R8 pulse one cycle", 64'(wr_err), 64'd0);
        rd(1, 64'h10, "R8 register unchanged");
        wr(1, 64'h34);
        chk("R8 read-only bits no error", 64'(wr_err), 64'd0);
        rd(1, 64'h10, "R8 read-only bits ignored");
        chk("R8 gather unchanged", 64'(gath_mitig_off), 64'd1);

        // R9 out-of-range index
        wr(3, 64'h01);
        chk("R9 bad index error", 64'(wr_err), 64'd1);
        rd(3, 64'h00, "R9 bad index reads zero");
        rd(0, 64'h10, "R9 no thread touched");

        // R7 load-time gather lock
        @(negedge clk); load_evt = 1'b1;
        @(negedge clk); load_evt = 1'b0;
        @(negedge clk);
        chk("R7 gather forced on", 64'(gath_mitig_off), 64'd0);
        for (int t = 0; t < NT; t++) rd(t, 64'h20, "R7 lock image");
        wr(0, 64'h10);
        rd(0, 64'h20, "R7 write to bit 4 ignored");
        repeat (4) @(negedge clk);
        chk("R7 lock holds", 64'(gath_mitig_off), 64'd0);
        rd(2, 64'h20, "R7 lock persists");

        // R1 reset clears the lock
        do_reset();
        @(negedge clk);
        rd(0, 64'h40, "R1 reset clears lock");
        chk("R1 gather after reset", 64'(gath_mitig_off), 64'd0);

        repeat (2) @(negedge clk);
        chk("R2 all responses seen", 64'(exp_q.size()), 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule